// File: doc/BRIEF.md
# Background Memory Scrub Sequencer

This block walks a programmed window of ECC-protected memory word by word, issuing one read at a time to a simple read-response port and noting whether each returned word carried a correctable error. Software programs a 34-bit first and last address, a burst length, an idle gap and a pacing mode through a small write port, then writes a launch bit. While the walk runs, a read-only in-progress flag is visible on the register read port. When the final address has been read, a one-cycle completion event is raised; every scrub read that reports a correctable error raises a separate one-cycle event. Both events appear on a 16-bit event vector that feeds an interrupt status register elsewhere.

In paced mode the walk is split into bursts of `length` reads. After each full burst that is not the last, the engine stays off the memory port for `idle` clock cycles. In continuous mode no gap is inserted. Only one read is outstanding at any time.

The sequencer is a five-state machine. IDLE waits for a launch. ISSUE drives a request until it is accepted (ISSUE to WAIT). WAIT holds until the response arrives, then goes to DONE if the address just read is the last one, to GAP if a full burst ended in paced mode with a non-zero gap, and otherwise back to ISSUE. GAP counts the idle cycles down and returns to ISSUE. DONE lasts one cycle, pulses completion and returns to IDLE, or to ISSUE if a new launch arrives in that cycle.

Top module: `scrub_engine`

## Requirements
- R1: After reset `mem_req` is 0, `irq_evt` is all zero and the in-progress flag (bit 8 of the word read at offset 6) is 0.
- R2: Writing bit 0 = 1 at offset 6 while idle starts a walk whose first request address is the start address: bits [31:0] from offset 0 and bits [33:32] from bits [1:0] of offset 1.
- R3: Requests step through consecutive addresses, carrying from bit 31 into bit 32, and the last address read is the end address (bits [31:0] at offset 2, bits [33:32] from bits [1:0] of offset 3); the walk then stops.
- R4: When the end address is lower than the start address, or equal to it, exactly one read (of the start address) is made before completion.
- R5: With the mode bit (offset 5, bit 0) = 1, the length in bits [27:16] and the idle count in bits [15:0] of offset 4 apply: after every full burst of `length` reads that does not end the walk, the engine is busy with no request and no read outstanding for exactly `idle` cycles. A length of 0 acts as 1.
- R6: With the mode bit = 0, no idle cycles are ever inserted between reads.
- R7: Completion is `irq_evt[7]`, high for one cycle, once per walk, in the cycle after the final response is accepted; the in-progress flag is 0 in that cycle.
- R8: Each response accepted with `resp_ce` = 1 produces one one-cycle pulse on `irq_evt[8]` in the next cycle; responses without it produce none.
- R9: The in-progress flag reads 1 from the cycle after launch until completion.
- R10: A launch written while a walk is in progress is ignored: the running walk keeps its addresses and completes once.
- R11: A request is held with a stable address until accepted, and no new request is made while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_ofs | input | 3 | Register write offset |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_ofs | input | 3 | Register read offset |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Scrub read request |
| mem_addr | output | 34 | Scrub read word address |
| mem_ready | input | 1 | Request accepted this cycle |
| resp_valid | input | 1 | Read response present |
| resp_ce | input | 1 | Response held a correctable error |
| irq_evt | output | 16 | Event pulses: bit 7 completion, bit 8 correctable error found |

## Verification
A launch is taken at the clock edge that samples the write, so the first request is visible one cycle later; a response moves the machine at the edge that samples it, the completion pulse is visible in the following cycle, and the correctable-error pulse is registered one cycle after its response, which places the last one in the same cycle as completion. The bench drives inputs and samples outputs on the falling edge, counts accepted addresses, idle cycles and event pulses per walk, and compares them with values computed from the window, burst length, gap and mode only after completion plus three settling cycles. Gap cycles are counted as cycles with the flag set, no request and nothing outstanding, which matches the requirement directly and excludes the wait for each response.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 34;
    localparam int LEN_W    = 12;
    localparam int IDLE_W   = 16;
    localparam int LEN_LSB  = 16;
    localparam int OFS_W    = 3;
    localparam int BUSY_BIT = 8;
    localparam int EVT_W    = 16;
    localparam int EVT_DONE = 7;
    localparam int EVT_CE   = 8;

    localparam logic [OFS_W-1:0] OFS_FIRST_LO = 3'd0;
    localparam logic [OFS_W-1:0] OFS_FIRST_HI = 3'd1;
    localparam logic [OFS_W-1:0] OFS_LAST_LO  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_LAST_HI  = 3'd3;
    localparam logic [OFS_W-1:0] OFS_PACE     = 3'd4;
    localparam logic [OFS_W-1:0] OFS_MODE     = 3'd5;
    localparam logic [OFS_W-1:0] OFS_LAUNCH   = 3'd6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_GAP,
        S_DONE
    } scrub_state_t;
endpackage

// File: rtl/scrub_regs.sv
module scrub_regs
    import scrub_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int LW  = LEN_W,
    parameter int IW  = IDLE_W,
    parameter int LSB = LEN_LSB,
    parameter int OW  = OFS_W,
    parameter int BB  = BUSY_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_ofs,
    input  logic [DW-1:0] wr_data,
    input  logic [OW-1:0] rd_ofs,
    input  logic          busy,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] last_addr,
    output logic [LW-1:0] burst_len,
    output logic [IW-1:0] idle_len,
    output logic          paced,
    output logic          launch
);
    localparam int HW = AW - DW;

    logic [DW-1:0] first_lo, last_lo;
    logic [HW-1:0] first_hi, last_hi;
    logic [LW-1:0] len_r;
    logic [IW-1:0] idle_r;
    logic          mode_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_lo <= '0;
            first_hi <= '0;
            last_lo  <= '0;
            last_hi  <= '0;
            len_r    <= '0;
            idle_r   <= '0;
            mode_r   <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_ofs)
                OFS_FIRST_LO: first_lo <= wr_data;
                OFS_FIRST_HI: first_hi <= wr_data[HW-1:0];
                OFS_LAST_LO:  last_lo  <= wr_data;
                OFS_LAST_HI:  last_hi  <= wr_data[HW-1:0];
                OFS_PACE: begin
                    len_r  <= wr_data[LSB +: LW];
                    idle_r <= wr_data[IW-1:0];
                end
                OFS_MODE:     mode_r   <= wr_data[0];
                default: ;
            endcase
        end
    end

    assign launch     = wr_en && (wr_ofs == OFS_LAUNCH) && wr_data[0];
    assign first_addr = {first_hi, first_lo};
    assign last_addr  = {last_hi, last_lo};
    assign burst_len  = len_r;
    assign idle_len   = idle_r;
    assign paced      = mode_r;

    always_comb begin
        rd_data = '0;
        unique case (rd_ofs)
            OFS_FIRST_LO: rd_data = first_lo;
            OFS_FIRST_HI: rd_data[HW-1:0] = first_hi;
            OFS_LAST_LO:  rd_data = last_lo;
            OFS_LAST_HI:  rd_data[HW-1:0] = last_hi;
            OFS_PACE: begin
                rd_data[LSB +: LW] = len_r;
                rd_data[IW-1:0]    = idle_r;
            end
            OFS_MODE:     rd_data[0]  = mode_r;
            OFS_LAUNCH:   rd_data[BB] = busy;
            default: ;
        endcase
    end
endmodule

// File: rtl/scrub_pacer.sv
module scrub_pacer
    import scrub_pkg::*;
#(
    parameter int LW = LEN_W,
    parameter int IW = IDLE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          beat,
    input  logic          gap_load,
    input  logic          gap_tick,
    input  logic [LW-1:0] burst_len,
    input  logic [IW-1:0] idle_len,
    output logic          burst_end,
    output logic          gap_last
);
    logic [LW-1:0] beat_cnt;
    logic [IW-1:0] gap_cnt;
    logic [LW-1:0] eff_len;

    assign eff_len   = (burst_len == '0) ? LW'(1) : burst_len;
    assign burst_end = (beat_cnt + LW'(1)) == eff_len;
    assign gap_last  = gap_cnt <= IW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (clear) begin
            beat_cnt <= '0;
        end else if (beat) begin
            beat_cnt <= burst_end ? '0 : beat_cnt + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (gap_load) begin
            gap_cnt <= idle_len;
        end else if (gap_tick && gap_cnt != '0) begin
            gap_cnt <= gap_cnt - IW'(1);
        end
    end

    // R5: the burst position never reaches the effective burst length
    p_beat_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_cnt < eff_len)
        else $error("beat counter beyond burst length");

    // R5: a gap is only loaded with a non-zero count
    p_gap_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_load |=> gap_cnt != '0)
        else $error("gap loaded with zero");
endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm
    import scrub_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W,
    parameter int IW = IDLE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    input  logic [LW-1:0] burst_len,
    input  logic [IW-1:0] idle_len,
    input  logic          paced,
    input  logic          mem_ready,
    input  logic          resp_valid,
    input  logic          resp_ce,
    input  logic          burst_end,
    input  logic          gap_last,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          busy,
    output logic          done_evt,
    output logic          ce_evt,
    output logic          pace_clear,
    output logic          beat,
    output logic          gap_load,
    output logic          gap_tick,
    output logic [LW-1:0] len_q,
    output logic [IW-1:0] idle_q
);
    scrub_state_t state, state_nx;
    logic [AW-1:0] cur_addr, end_q;
    logic          paced_q;
    logic          launch_ok;
    logic          at_last;
    logic          take_gap;

    assign launch_ok = launch && (state == S_IDLE || state == S_DONE);
    assign at_last   = cur_addr >= end_q;
    assign take_gap  = burst_end && paced_q && (idle_q != '0);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (launch_ok) state_nx = S_ISSUE;
            S_ISSUE: if (mem_ready) state_nx = S_WAIT;
            S_WAIT: begin
                if (resp_valid) begin
                    if (at_last)       state_nx = S_DONE;
                    else if (take_gap) state_nx = S_GAP;
                    else               state_nx = S_ISSUE;
                end
            end
            S_GAP:   if (gap_last) state_nx = S_ISSUE;
            S_DONE:  state_nx = launch_ok ? S_ISSUE : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            end_q    <= '0;
            len_q    <= '0;
            idle_q   <= '0;
            paced_q  <= 1'b0;
        end else if (launch_ok) begin
            cur_addr <= first_addr;
            end_q    <= last_addr;
            len_q    <= burst_len;
            idle_q   <= idle_len;
            paced_q  <= paced;
        end else if (beat) begin
            cur_addr <= cur_addr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_evt <= 1'b0;
        else        ce_evt <= (state == S_WAIT) && resp_valid && resp_ce;
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        busy       = 1'b0;
        done_evt   = 1'b0;
        beat       = 1'b0;
        gap_load   = 1'b0;
        gap_tick   = 1'b0;
        pace_clear = launch_ok;
        unique case (state)
            S_IDLE: ;
            S_ISSUE: begin
                mem_req = 1'b1;
                busy    = 1'b1;
            end
            S_WAIT: begin
                busy     = 1'b1;
                beat     = resp_valid && !at_last;
                gap_load = resp_valid && !at_last && take_gap;
            end
            S_GAP: begin
                busy     = 1'b1;
                gap_tick = 1'b1;
            end
            S_DONE:  done_evt = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr = cur_addr;

    // R11: an unaccepted request stays up with the same address
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)))
        else $error("request dropped or address moved");

    // R11: no request right after acceptance (read outstanding)
    p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> !mem_req)
        else $error("second request while outstanding");

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !done_evt)
        else $error("completion longer than one cycle");

    // R7: not in progress while completion pulses
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> !busy)
        else $error("busy during completion");

    // R8: correctable pulse only follows a flagged response
    p_ce_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt |-> $past(resp_valid && resp_ce))
        else $error("spurious correctable event");

    // R10: launch during a walk leaves the end address alone
    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && launch) |=> $stable(end_q))
        else $error("launch accepted while busy");
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
    import scrub_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int OW = OFS_W,
    parameter int EW = EVT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [OW-1:0] cfg_wr_ofs,
    input  logic [DW-1:0] cfg_wr_data,
    input  logic [OW-1:0] cfg_rd_ofs,
    output logic [DW-1:0] cfg_rd_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ready,
    input  logic          resp_valid,
    input  logic          resp_ce,
    output logic [EW-1:0] irq_evt
);
    logic [AW-1:0]     first_addr, last_addr;
    logic [LEN_W-1:0]  burst_len, len_q;
    logic [IDLE_W-1:0] idle_len, idle_q;
    logic paced, launch, busy, done_evt, ce_evt;
    logic pace_clear, beat, gap_load, gap_tick, burst_end, gap_last;

    scrub_regs #(.DW(DW), .AW(AW), .OW(OW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_ofs(cfg_wr_ofs), .wr_data(cfg_wr_data),
        .rd_ofs(cfg_rd_ofs), .busy(busy), .rd_data(cfg_rd_data),
        .first_addr(first_addr), .last_addr(last_addr),
        .burst_len(burst_len), .idle_len(idle_len),
        .paced(paced), .launch(launch)
    );

    scrub_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .first_addr(first_addr), .last_addr(last_addr),
        .burst_len(burst_len), .idle_len(idle_len), .paced(paced),
        .mem_ready(mem_ready), .resp_valid(resp_valid), .resp_ce(resp_ce),
        .burst_end(burst_end), .gap_last(gap_last),
        .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy),
        .done_evt(done_evt), .ce_evt(ce_evt), .pace_clear(pace_clear),
        .beat(beat), .gap_load(gap_load), .gap_tick(gap_tick),
        .len_q(len_q), .idle_q(idle_q)
    );

    scrub_pacer u_pacer (
        .clk(clk), .rst_n(rst_n), .clear(pace_clear), .beat(beat),
        .gap_load(gap_load), .gap_tick(gap_tick),
        .burst_len(len_q), .idle_len(idle_q),
        .burst_end(burst_end), .gap_last(gap_last)
    );

    for (genvar g = 0; g < EW; g++) begin : g_evt
        if (g == EVT_DONE) begin : g_done
            assign irq_evt[g] = done_evt;
        end else if (g == EVT_CE) begin : g_ce
            assign irq_evt[g] = ce_evt;
        end else begin : g_zero
            assign irq_evt[g] = 1'b0;
        end
    end
endmodule

// File: tb/scrub_engine_bench.sv
module scrub_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_ofs = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [2:0]  cfg_rd_ofs = 3'd6;
    logic [31:0] cfg_rd_data;
    logic        mem_req;
    logic [33:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic        resp_valid = 1'b0;
    logic        resp_ce = 1'b0;
    logic [15:0] irq_evt;

    scrub_engine u_scrub_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_ofs(cfg_wr_ofs),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_ofs(cfg_rd_ofs), .cfg_rd_data(cfg_rd_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .resp_valid(resp_valid), .resp_ce(resp_ce), .irq_evt(irq_evt)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit wd = 1'b0;
    // per-walk monitor state
    bit          outstanding = 1'b0;
    int          lat = 0;
    logic [33:0] lat_addr;
    logic [33:0] exp_next;
    int          acc_cnt, addr_err, done_cnt, ce_cnt, gap_cnt, done_busy;
    logic [3:0]  ce_key = 4'd3;

    function automatic bit ce_of(logic [33:0] a, logic [3:0] k);
        return (a[3:0] ^ k) < 4'd3;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !wd) begin
            wd = 1'b1;
        end
        if (irq_evt[7]) begin
            done_cnt++;
            if (cfg_rd_data[8]) done_busy++;
        end
        if (irq_evt[8]) ce_cnt++;
        if (resp_valid) begin
            resp_valid = 1'b0;
            resp_ce = 1'b0;
            outstanding = 1'b0;
        end else if (outstanding) begin
            if (lat == 0) begin
                resp_valid = 1'b1;
                resp_ce = ce_of(lat_addr, ce_key);
            end else lat--;
        end
        if (rst_n && cfg_rd_data[8] && !mem_req && !outstanding) gap_cnt++;
        mem_ready = 1'b0;
        if (!outstanding && mem_req && ($urandom % 3 != 0)) begin
            mem_ready = 1'b1;
            outstanding = 1'b1;
            lat = int'($urandom % 4);
            lat_addr = mem_addr;
            if (mem_addr !== exp_next) addr_err++;
            exp_next = exp_next + 34'd1;
            acc_cnt++;
        end
    end

    task automatic wr(logic [2:0] ofs, logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_ofs = ofs;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic walk(logic [33:0] s, logic [33:0] e, int len, int idle,
                        bit mode, bit disturb, string tag);
        longint n, el, gaps, exp_ce;
        @(posedge clk); #1;
        acc_cnt = 0; addr_err = 0; done_cnt = 0; ce_cnt = 0; gap_cnt = 0;
        done_busy = 0; exp_next = s;
        ce_key = 4'($urandom);
        n = (e < s) ? 1 : longint'(e - s) + 1;
        el = (len == 0) ? 1 : len;
        gaps = (mode && idle != 0) ? ((n - 1) / el) * idle : 0;
        exp_ce = 0;
        for (longint i = 0; i < n; i++) exp_ce += ce_of(s + 34'(i), ce_key);
        wr(3'd0, s[31:0]);
        wr(3'd1, {30'd0, s[33:32]});
        wr(3'd2, e[31:0]);
        wr(3'd3, {30'd0, e[33:32]});
        wr(3'd4, {4'd0, 12'(len), 16'(idle)});
        wr(3'd5, {31'd0, mode});
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_ofs = 3'd6; cfg_wr_data = 32'd1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        // R9: flag visible one cycle after launch
        chk(cfg_rd_data[8] == 1'b1 || done_cnt != 0, {tag, " R9 busy after launch"},
            longint'(cfg_rd_data[8]), 1);
        if (disturb) begin
            repeat (4) @(negedge clk);
            wr(3'd0, 32'h0000_0500);
            wr(3'd6, 32'd1);
        end
        while (done_cnt == 0 && !wd) @(posedge clk);
        repeat (3) @(negedge clk);
        chk(addr_err == 0, {tag, " R2 R3 address order"}, addr_err, 0);
        chk(acc_cnt == n, {tag, " R3 R4 read count"}, acc_cnt, n);
        chk(done_cnt == 1, {tag, " R7 R10 completion count"}, done_cnt, 1);
        chk(done_busy == 0, {tag, " R7 busy at completion"}, done_busy, 0);
        chk(ce_cnt == exp_ce, {tag, " R8 correctable events"}, ce_cnt, exp_ce);
        chk(gap_cnt == gaps, {tag, mode ? " R5 idle cycles" : " R6 idle cycles"},
            gap_cnt, gaps);
        chk(cfg_rd_data[8] == 1'b0, {tag, " R9 flag cleared"}, longint'(cfg_rd_data[8]), 0);
    endtask

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_req == 1'b0, "R1 no request in reset", longint'(mem_req), 0);
        chk(irq_evt == 16'd0, "R1 no events in reset", longint'(irq_evt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rd_data[8] == 1'b0, "R1 flag clear after reset", longint'(cfg_rd_data[8]), 0);
        chk(mem_req == 1'b0 && irq_evt == 16'd0, "R1 quiet after reset",
            longint'(irq_evt), 0);

        walk(34'h10, 34'h1F, 4, 3, 1'b1, 1'b0, "paced4x3");
        walk(34'h0_FFFF_FFFC, 34'h1_0000_0003, 2, 5, 1'b0, 1'b0, "carry32");
        walk(34'h100, 34'h0FF, 3, 2, 1'b1, 1'b0, "end_below_R4");
        walk(34'h2_0000_0040, 34'h2_0000_0040, 1, 1, 1'b1, 1'b0, "single_R4");
        walk(34'h40, 34'h44, 0, 2, 1'b1, 1'b0, "len0_R5");
        walk(34'h60, 34'h6B, 2, 0, 1'b1, 1'b0, "idle0_R5");
        walk(34'h200, 34'h21F, 3, 2, 1'b1, 1'b1, "relaunch_R10");
        walk(34'h3_FFFF_FFFE, 34'h3_FFFF_FFFF, 1, 4, 1'b1, 1'b0, "top");
        for (int k = 0; k < 8; k++) begin
            logic [33:0] s;
            int sp;
            s = {2'($urandom), 32'($urandom)};
            sp = int'($urandom % 40);
            walk(s, s + 34'(sp), int'($urandom % 8), int'($urandom % 7),
                 1'($urandom), 1'b0, "random");
        end
        if (wd) begin
            checks++; errors++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 150000);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule